// File: doc/BRIEF.md
# Instruction Prefix and Escape Decoder

This block is the byte-serial front end of an instruction decoder. It accepts one instruction byte per cycle over a valid/ready stream. It collects the legacy prefixes and an optional REX byte, follows the `0F` and `0F 38` escape bytes, and latches the opcode byte that ends the instruction. It then emits one decoded record that gives the opcode map, the opcode, the mandatory prefix resolved for SIMD maps, the raw operand-size and repeat prefixes, a branch hint, the REX bits, the byte count and, for the `0F 58` add family, its packed or scalar and single or double class.

The front end does not touch ModR/M, displacement or immediate bytes. It stops at the opcode byte, and a later stage parses whatever follows. While a decoded record waits to be taken, the input stream is stalled. An instruction that cannot end within the length limit produces a one-cycle error pulse and is discarded.

Top module: `insn_prefix_decoder`

## Requirements
- R1: After a synchronous reset, `out_valid` and `err` are 0 and `in_ready` is 1.
- R2: `0F xx` reports map 1 and `0F 38 xx` reports map 2, with `xx` as the opcode. A bare opcode reports map 0. The map codes are 0, 1 and 2 respectively.
- R3: For map 1 opcode `58`, the add class is 1 (packed single) with no mandatory prefix, 2 (packed double) with 66h, 4 (scalar double) with F2h and 3 (scalar single) with F3h. Every other opcode reports class 0.
- R4: When both F2h and F3h appear, the one received last sets the repeat field and the mandatory prefix. The repeat codes are 0 none, 1 F2h, 2 F3h. The mandatory prefix codes are 0 none, 1 66h, 2 F2h, 3 F3h.
- R5: On maps 1 and 2, a repeat prefix becomes the mandatory prefix whether it comes before or after 66h. `out_opsize` still reports that 66h was seen.
- R6: A REX byte (40h to 4Fh) is reported only when no other prefix follows it. A later legacy prefix clears it, and prefix collection continues.
- R7: On map 0, the mandatory prefix is always 0. The operand-size and repeat prefixes pass through on `out_opsize` and `out_rep`. Repeating a prefix does not change the decode.
- R8: On a conditional jump (map 0 opcodes 70h to 7Fh, map 1 opcodes 80h to 8Fh), a last segment byte of 2Eh gives hint 2 (not taken) and 3Eh gives hint 1 (taken). Every other case gives hint 0.
- R9: `out_len` gives the number of bytes in the instruction. If the 15th byte does not end the instruction, `err` pulses for one cycle, no record is produced, and the decoder returns to idle with its prefixes cleared.
- R10: The record appears on the cycle after its final byte is accepted. It holds steady while `out_ready` is low, and `in_ready` stays low for as long as `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_ready | input | 1 | Consumer takes the record |
| out_valid | output | 1 | Decoded record is present |
| out_map | output | 2 | Opcode map |
| out_opcode | output | 8 | Opcode byte |
| out_mprefix | output | 2 | Resolved mandatory prefix |
| out_opsize | output | 1 | 66h was seen |
| out_rep | output | 2 | Last repeat prefix |
| out_hint | output | 2 | Branch hint |
| out_rex_valid | output | 1 | A REX byte is in effect |
| out_rex | output | 4 | REX W, R, X, B bits |
| out_add_class | output | 3 | Add-family class |
| out_len | output | 4 | Instruction length in bytes |
| err | output | 1 | Length overflow pulse |

## Verification
On every cycle, the assertions check several invariants: a record is stable while it is stalled, a record only appears after a byte was accepted, map 0 never carries a mandatory prefix, a repeat prefix never resolves to 66h, an add class only appears on `0F 58`, a hint only appears on a conditional jump, the error pulse and a record never coincide, a REX is dropped after a later legacy prefix, and the byte counter stays under the limit. Some behaviours depend on which byte sequence produced a record, and only the bench's scenarios can show them: last-wins ordering, precedence over 66h in both orders, exact class and hint values, REX position, padding, and recovery after an overflow.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    localparam int unsigned MAX_LEN = 15;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

    typedef enum logic [1:0] {MAP_ONE = 2'd0, MAP_0F = 2'd1, MAP_0F38 = 2'd2} map_e;
    typedef enum logic [1:0] {MP_NONE = 2'd0, MP_66 = 2'd1, MP_F2 = 2'd2, MP_F3 = 2'd3} mprefix_e;
    typedef enum logic [1:0] {REP_NONE = 2'd0, REP_NE = 2'd1, REP_E = 2'd2} rep_e;
    typedef enum logic [1:0] {HINT_NONE = 2'd0, HINT_TAKEN = 2'd1, HINT_NOT_TAKEN = 2'd2} hint_e;
    typedef enum logic [2:0] {CLS_NONE = 3'd0, CLS_PS = 3'd1, CLS_PD = 3'd2,
                              CLS_SS = 3'd3, CLS_SD = 3'd4} add_cls_e;
    typedef enum logic [2:0] {BK_OPSZ, BK_REP, BK_SEG, BK_LEGACY, BK_REX, BK_ESC, BK_FINAL} byte_kind_e;
    typedef enum logic [1:0] {ST_PFX, ST_ESC, ST_ESC38} dec_state_e;

    typedef struct packed {
        logic       opsz;
        rep_e       rep;
        logic [7:0] seg;
        logic       rex_v;
        logic [3:0] rex;
    } pfx_state_t;

    typedef struct packed {
        map_e             map;
        logic [7:0]       opcode;
        mprefix_e         mp;
        logic             opsz;
        rep_e             rep;
        hint_e            hint;
        logic             rex_v;
        logic [3:0]       rex;
        add_cls_e         cls;
        logic [LEN_W-1:0] len;
    } insn_rec_t;

    function automatic byte_kind_e kind_of(input logic [7:0] b);
        byte_kind_e k;
        unique case (b)
            8'h66:                                  k = BK_OPSZ;
            8'hF2, 8'hF3:                           k = BK_REP;
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: k = BK_SEG;
            8'hF0, 8'h67:                           k = BK_LEGACY;
            8'h0F:                                  k = BK_ESC;
            default:                                k = (b[7:4] == 4'h4) ? BK_REX : BK_FINAL;
        endcase
        return k;
    endfunction

    function automatic logic is_cond_jump(input map_e m, input logic [7:0] op);
        return ((m == MAP_ONE) && (op[7:4] == 4'h7)) || ((m == MAP_0F) && (op[7:4] == 4'h8));
    endfunction

endpackage

// File: rtl/ipd_prefix_accum.sv
module ipd_prefix_accum
    import ipd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd,
    input  logic       clear,
    input  logic [7:0] in_byte,
    input  byte_kind_e kind,
    output pfx_state_t st
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st <= '0;
        end else if (upd) begin
            unique case (kind)
                BK_OPSZ: begin
                    st.opsz  <= 1'b1;
                    st.rex_v <= 1'b0;
                    st.rex   <= '0;
                end
                BK_REP: begin
                    st.rep   <= (in_byte == 8'hF2) ? REP_NE : REP_E;
                    st.rex_v <= 1'b0;
                    st.rex   <= '0;
                end
                BK_SEG: begin
                    st.seg   <= in_byte;
                    st.rex_v <= 1'b0;
                    st.rex   <= '0;
                end
                BK_LEGACY: begin
                    st.rex_v <= 1'b0;
                    st.rex   <= '0;
                end
                BK_REX: begin
                    st.rex_v <= 1'b1;
                    st.rex   <= in_byte[3:0];
                end
                default: ;
            endcase
        end
    end

    // R6
    rex_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !clear && (kind inside {BK_OPSZ, BK_REP, BK_SEG, BK_LEGACY})) |=> !st.rex_v);

endmodule

// File: rtl/ipd_len_guard.sv
module ipd_len_guard
    import ipd_pkg::*;
#(
    parameter int unsigned LIMIT = MAX_LEN,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          final_byte,
    output logic [CW-1:0] cnt,
    output logic          overflow
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    assign overflow = accept && !final_byte && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (accept) begin
            if (final_byte || overflow) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

endmodule

// File: rtl/ipd_resolve.sv
module ipd_resolve
    import ipd_pkg::*;
(
    input  pfx_state_t       st,
    input  map_e             map,
    input  logic [7:0]       opcode,
    input  logic [LEN_W-1:0] prior_cnt,
    output insn_rec_t        rec
);

    always_comb begin
        rec        = '0;
        rec.map    = map;
        rec.opcode = opcode;
        rec.opsz   = st.opsz;
        rec.rep    = st.rep;
        rec.rex_v  = st.rex_v;
        rec.rex    = st.rex;
        rec.len    = prior_cnt + 1'b1;

        if (map == MAP_ONE)        rec.mp = MP_NONE;
        else if (st.rep == REP_NE) rec.mp = MP_F2;
        else if (st.rep == REP_E)  rec.mp = MP_F3;
        else if (st.opsz)          rec.mp = MP_66;
        else                       rec.mp = MP_NONE;

        rec.cls = CLS_NONE;
        if (map == MAP_0F && opcode == 8'h58) begin
            unique case (rec.mp)
                MP_NONE: rec.cls = CLS_PS;
                MP_66:   rec.cls = CLS_PD;
                MP_F2:   rec.cls = CLS_SD;
                MP_F3:   rec.cls = CLS_SS;
                default: rec.cls = CLS_NONE;
            endcase
        end

        rec.hint = HINT_NONE;
        if (is_cond_jump(map, opcode)) begin
            if (st.seg == 8'h2E)      rec.hint = HINT_NOT_TAKEN;
            else if (st.seg == 8'h3E) rec.hint = HINT_TAKEN;
        end
    end

endmodule

// File: rtl/insn_prefix_decoder.sv
module insn_prefix_decoder
    import ipd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [1:0]       out_map,
    output logic [7:0]       out_opcode,
    output logic [1:0]       out_mprefix,
    output logic             out_opsize,
    output logic [1:0]       out_rep,
    output logic [1:0]       out_hint,
    output logic             out_rex_valid,
    output logic [3:0]       out_rex,
    output logic [2:0]       out_add_class,
    output logic [LEN_W-1:0] out_len,
    output logic             err
);

    dec_state_e       state_q;
    byte_kind_e       kind;
    pfx_state_t       pfx;
    insn_rec_t        rec_d, rec_q;
    map_e             map_d;
    logic             accept, final_byte, overflow, valid_q, err_q;
    logic [LEN_W-1:0] cnt;

    assign in_ready = !valid_q;
    assign accept   = in_valid && in_ready;
    assign kind     = kind_of(in_byte);

    always_comb begin
        final_byte = 1'b0;
        map_d      = MAP_ONE;
        unique case (state_q)
            ST_PFX: begin
                final_byte = (kind == BK_FINAL);
                map_d      = MAP_ONE;
            end
            ST_ESC: begin
                final_byte = (in_byte != 8'h38);
                map_d      = MAP_0F;
            end
            ST_ESC38: begin
                final_byte = 1'b1;
                map_d      = MAP_0F38;
            end
            default: ;
        endcase
    end

    ipd_prefix_accum i_accum (
        .clk     (clk),
        .rst     (rst),
        .upd     (accept && state_q == ST_PFX),
        .clear   ((accept && final_byte) || overflow),
        .in_byte (in_byte),
        .kind    (kind),
        .st      (pfx)
    );

    ipd_len_guard #(.LIMIT(MAX_LEN)) i_len (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .final_byte (final_byte),
        .cnt        (cnt),
        .overflow   (overflow)
    );

    ipd_resolve i_resolve (
        .st        (pfx),
        .map       (map_d),
        .opcode    (in_byte),
        .prior_cnt (cnt),
        .rec       (rec_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PFX;
        end else if (accept) begin
            if (final_byte || overflow)                     state_q <= ST_PFX;
            else if (state_q == ST_PFX && kind == BK_ESC)   state_q <= ST_ESC;
            else if (state_q == ST_ESC)                     state_q <= ST_ESC38;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            rec_q   <= '0;
        end else begin
            err_q <= overflow;
            if (accept && final_byte) begin
                valid_q <= 1'b1;
                rec_q   <= rec_d;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid     = valid_q;
    assign err           = err_q;
    assign out_map       = rec_q.map;
    assign out_opcode    = rec_q.opcode;
    assign out_mprefix   = rec_q.mp;
    assign out_opsize    = rec_q.opsz;
    assign out_rep       = rec_q.rep;
    assign out_hint      = rec_q.hint;
    assign out_rex_valid = rec_q.rex_v;
    assign out_rex       = rec_q.rex;
    assign out_add_class = rec_q.cls;
    assign out_len       = rec_q.len;

    // R10
    hold_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(rec_q)));

    // R10
    rec_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid));

    // R3
    class_on_add_only_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_add_class != 3'd0) |-> (out_map == 2'd1 && out_opcode == 8'h58));

    // R7
    map0_no_mprefix_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_map == 2'd0) |-> (out_mprefix == 2'd0));

    // R5
    rep_beats_opsz_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_map != 2'd0 && out_rep != 2'd0) |-> (out_mprefix inside {2'd2, 2'd3}));

    // R8
    hint_on_jcc_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hint != 2'd0) |-> is_cond_jump(map_e'(out_map), out_opcode));

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(err && out_valid));

endmodule

// File: tb/test_insn_prefix_decoder.sv
module test_insn_prefix_decoder;
    import ipd_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_ready, out_ready, out_valid;
    logic [1:0] out_map, out_mprefix, out_rep, out_hint;
    logic [7:0] out_opcode;
    logic out_opsize, out_rex_valid, err;
    logic [3:0] out_rex;
    logic [2:0] out_add_class;
    logic [LEN_W-1:0] out_len;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] seq [0:15];
    int seq_n = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    insn_prefix_decoder i_insn_prefix_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid), .out_map(out_map), .out_opcode(out_opcode),
        .out_mprefix(out_mprefix), .out_opsize(out_opsize), .out_rep(out_rep), .out_hint(out_hint),
        .out_rex_valid(out_rex_valid), .out_rex(out_rex), .out_add_class(out_add_class),
        .out_len(out_len), .err(err)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        seq[seq_n] = b;
        seq_n++;
    endtask

    // called at a negedge; returns at the negedge after the last byte was accepted
    task automatic send();
        for (int i = 0; i < seq_n; i++) begin
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = seq[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        seq_n = 0;
    endtask

    task automatic expect_rec(input string req, input int map, input int op, input int mp,
                              input int opsz, input int rep, input int hint, input int rexv,
                              input int rex, input int cls, input int len);
        chk(req, "out_valid", out_valid, 1);
        chk(req, "map", out_map, map);
        chk(req, "opcode", out_opcode, op);
        chk(req, "mprefix", out_mprefix, mp);
        chk(req, "opsize", out_opsize, opsz);
        chk(req, "rep", out_rep, rep);
        chk(req, "hint", out_hint, hint);
        chk(req, "rex_valid", out_rex_valid, rexv);
        chk(req, "rex", out_rex, rex);
        chk(req, "class", out_add_class, cls);
        chk(req, "len", out_len, len);
        @(negedge clk);
        chk("R10", "one-cycle valid", out_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "err", err, 0);
        chk("R1", "in_ready", in_ready, 1);
    endtask

    task automatic t_maps();
        push(8'h0F); push(8'h58); send();
        expect_rec("R2", 1, 8'h58, 0, 0, 0, 0, 0, 0, 1, 2);
        push(8'h66); push(8'h0F); push(8'h38); push(8'h01); send();
        expect_rec("R2", 2, 8'h01, 1, 1, 0, 0, 0, 0, 0, 4);
        push(8'h90); send();
        expect_rec("R2", 0, 8'h90, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_add_class();
        push(8'h66); push(8'h0F); push(8'h58); send();
        expect_rec("R3", 1, 8'h58, 1, 1, 0, 0, 0, 0, 2, 3);
        push(8'hF2); push(8'h0F); push(8'h58); send();
        expect_rec("R3", 1, 8'h58, 2, 0, 1, 0, 0, 0, 4, 3);
        push(8'hF3); push(8'h0F); push(8'h58); send();
        expect_rec("R3", 1, 8'h58, 3, 0, 2, 0, 0, 0, 3, 3);
        push(8'hF3); push(8'h0F); push(8'h59); send();
        expect_rec("R3", 1, 8'h59, 3, 0, 2, 0, 0, 0, 0, 3);
    endtask

    task automatic t_last_wins();
        push(8'hF2); push(8'hF3); push(8'h0F); push(8'h58); send();
        expect_rec("R4", 1, 8'h58, 3, 0, 2, 0, 0, 0, 3, 4);
        push(8'hF3); push(8'hF2); push(8'h0F); push(8'h58); send();
        expect_rec("R4", 1, 8'h58, 2, 0, 1, 0, 0, 0, 4, 4);
    endtask

    task automatic t_rep_over_opsz();
        push(8'h66); push(8'hF2); push(8'h0F); push(8'h58); send();
        expect_rec("R5", 1, 8'h58, 2, 1, 1, 0, 0, 0, 4, 4);
        push(8'hF2); push(8'h66); push(8'h0F); push(8'h58); send();
        expect_rec("R5", 1, 8'h58, 2, 1, 1, 0, 0, 0, 4, 4);
    endtask

    task automatic t_rex();
        push(8'h48); push(8'h0F); push(8'h58); send();
        expect_rec("R6", 1, 8'h58, 0, 0, 0, 0, 1, 8, 1, 3);
        push(8'h4D); push(8'h66); push(8'h0F); push(8'h58); send();
        expect_rec("R6", 1, 8'h58, 1, 1, 0, 0, 0, 0, 2, 4);
        push(8'h66); push(8'h41); push(8'h90); send();
        expect_rec("R6", 0, 8'h90, 0, 1, 0, 0, 1, 1, 0, 3);
    endtask

    task automatic t_map0_padding();
        push(8'h66); push(8'h66); push(8'h90); send();
        expect_rec("R7", 0, 8'h90, 0, 1, 0, 0, 0, 0, 0, 3);
        push(8'hF3); push(8'hA4); send();
        expect_rec("R7", 0, 8'hA4, 0, 0, 2, 0, 0, 0, 0, 2);
    endtask

    task automatic t_hints();
        push(8'h2E); push(8'h74); send();
        expect_rec("R8", 0, 8'h74, 0, 0, 0, 2, 0, 0, 0, 2);
        push(8'h3E); push(8'h0F); push(8'h84); send();
        expect_rec("R8", 1, 8'h84, 0, 0, 0, 1, 0, 0, 0, 3);
        push(8'h3E); push(8'h90); send();
        expect_rec("R8", 0, 8'h90, 0, 0, 0, 0, 0, 0, 0, 2);
        push(8'h2E); push(8'h3E); push(8'h75); send();
        expect_rec("R8", 0, 8'h75, 0, 0, 0, 1, 0, 0, 0, 3);
    endtask

    task automatic t_length();
        for (int i = 0; i < 14; i++) push(8'h66);
        push(8'h90); send();
        expect_rec("R9", 0, 8'h90, 0, 1, 0, 0, 0, 0, 0, 15);
        for (int i = 0; i < 15; i++) push(8'h66);
        send();
        chk("R9", "err pulse", err, 1);
        chk("R9", "no record", out_valid, 0);
        @(negedge clk);
        chk("R9", "err one cycle", err, 0);
        push(8'h0F); push(8'h58); send();
        expect_rec("R9", 1, 8'h58, 0, 0, 0, 0, 0, 0, 1, 2);
    endtask

    task automatic t_backpressure();
        out_ready = 1'b0;
        push(8'hF3); push(8'h0F); push(8'h58); send();
        in_valid = 1'b1;
        in_byte  = 8'h90;
        for (int i = 0; i < 3; i++) begin
            chk("R10", "held valid", out_valid, 1);
            chk("R10", "held class", out_add_class, 3);
            chk("R10", "in_ready low", in_ready, 0);
            @(negedge clk);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk("R10", "released", out_valid, 0);
        chk("R10", "ready again", in_ready, 1);
        push(8'h0F); push(8'h58); send();
        expect_rec("R10", 1, 8'h58, 0, 0, 0, 0, 0, 0, 1, 2);
    endtask

    initial begin
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_maps();
        t_add_class();
        t_last_wins();
        t_rep_over_opsz();
        t_rex();
        t_map0_padding();
        t_hints();
        t_length();
        t_backpressure();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule